// File: doc/BRIEF.md
# Byte Lane Manipulation Unit

This unit rearranges, clears and shifts the bytes of a 64-bit word so that software can assemble and split unaligned data. Operand A carries the data. Operand B carries a byte offset (its low three bits), a byte-select bitmap (its low eight bits) or a shift count (its low six bits), depending on the operation. A 7-bit function code picks the operation.

The operations are:
- mask-low and mask-high, which clear a byte, word, longword or quadword field;
- extract-low and extract-high, which pull such a field out to the bottom of the word;
- insert-low and insert-high, which place a low field at a byte offset;
- zap and zap-not, which clear whole bytes;
- logical left, logical right and arithmetic right shifts.

The result and an illegal-function flag are computed combinationally and registered. Both appear one clock after the inputs are presented.

Top module: `bytemix_unit`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge with reset released, `result` is 0 and `bad_func` is 0. Any input change reaches the outputs only at the next rising clock edge.
- R2: For mask, extract and insert codes, the byte offset is op_b[2:0] and the bit shift is eight times it. Bits op_b[63:3] have no effect. Function bits [5:4] select the field: 00 byte, 01 word (16), 10 longword (32), 11 quadword (64).
- R3: Mask-low codes 0x02/0x12/0x22/0x32 return A with the field-wide run of ones, shifted left by the offset, cleared.
- R4: Mask-high codes 0x52/0x62/0x72 return A with the field mask, shifted right by 64 minus the bit shift, cleared. They return A unchanged when the offset is 0.
- R5: Extract-low codes 0x06/0x16/0x26/0x36 shift A right logically by the bit shift and keep only the low field, zero-filled.
- R6: Extract-high codes 0x5A/0x6A/0x7A shift A left by (64 minus the bit shift) modulo 64 and keep only the low field.
- R7: Insert-low codes 0x0B/0x1B/0x2B/0x3B take the low field of A and shift it left by the bit shift.
- R8: Insert-high codes 0x57/0x67/0x77 take the low field of A and shift it right by 64 minus the bit shift. They return 0 when the offset is 0.
- R9: Code 0x30 clears byte i of A when op_b[i] is 1. Code 0x31 clears byte i of A when op_b[i] is 0, for i from 0 to 7.
- R10: Codes 0x39, 0x34 and 0x3C shift A left logically, right logically and right arithmetically by op_b[5:0].
- R11: Any other function code gives `bad_func` = 1 and `result` = 0. Every listed code gives `bad_func` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | Data operand |
| op_b | input | 64 | Offset, byte bitmap or shift count |
| func | input | 7 | Function code |
| result | output | 64 | Registered result |
| bad_func | output | 1 | Registered illegal-function flag |

## Verification
The bench goes after several corner cases:
- The high variants at offset 0, where a design that shifted by a full 64 would either wrap to a shift of 0 or leave stale bits. Mask-high would then clear the field instead of passing A through, and insert-high would leak the field instead of returning 0.
- Extract-high at offset 0, which must keep the unshifted low field.
- Random upper bits of B, which would expose a decoder that reads more than the offset bits.
- Every zap bitmap, which would catch the two zap polarities being swapped or a byte lane being miswired.
- All 128 function codes, which would reveal a code aliased onto a neighbour.
- Arithmetic shifts of negative values, which separate sign fill from zero fill.

// File: rtl/bytemix_pkg.sv
package bytemix_pkg;

    typedef enum logic [3:0] {
        K_MSKL, K_MSKH, K_EXTL, K_EXTH, K_INSL, K_INSH,
        K_ZAP, K_ZAPNOT, K_SLL, K_SRL, K_SRA, K_BAD
    } op_kind_e;

endpackage

// File: rtl/bytemix_decode.sv
module bytemix_decode
    import bytemix_pkg::*;
(
    input  logic [6:0] func,
    output op_kind_e   kind,
    output logic [1:0] size
);
    // Field size is carried in function bits [5:4] for every field op.
    assign size = func[5:4];

    always_comb begin
        case (func)
            7'h02, 7'h12, 7'h22, 7'h32: kind = K_MSKL;
            7'h52, 7'h62, 7'h72:        kind = K_MSKH;
            7'h06, 7'h16, 7'h26, 7'h36: kind = K_EXTL;
            7'h5A, 7'h6A, 7'h7A:        kind = K_EXTH;
            7'h0B, 7'h1B, 7'h2B, 7'h3B: kind = K_INSL;
            7'h57, 7'h67, 7'h77:        kind = K_INSH;
            7'h30:                      kind = K_ZAP;
            7'h31:                      kind = K_ZAPNOT;
            7'h39:                      kind = K_SLL;
            7'h34:                      kind = K_SRL;
            7'h3C:                      kind = K_SRA;
            default:                    kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/bytemix_field.sv
module bytemix_field
    import bytemix_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0]          a,
    input  logic [$clog2(DW/8)-1:0] off,
    input  logic [1:0]             size,
    input  op_kind_e               kind,
    output logic [DW-1:0]          res
);
    localparam int NB = DW / 8;
    localparam int SW = $clog2(DW);

    logic [DW-1:0] fmask;
    logic [SW-1:0] sh;
    logic [SW:0]   cpl;
    logic [SW-1:0] cpl_mod;
    logic          off_zero;

    // Field mask: the low 1, 2, 4 or 8 bytes set.
    always_comb begin
        fmask = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < (1 << size)) fmask[i*8 +: 8] = 8'hFF;
        end
    end

    assign sh       = {off, 3'b000};
    assign cpl      = (SW+1)'(DW) - {1'b0, sh};
    assign cpl_mod  = cpl[SW-1:0];
    assign off_zero = (off == '0);

    always_comb begin
        case (kind)
            K_MSKL:  res = a & ~(fmask << sh);
            K_MSKH:  res = off_zero ? a : (a & ~(fmask >> cpl));
            K_EXTL:  res = (a >> sh) & fmask;
            K_EXTH:  res = (a << cpl_mod) & fmask;
            K_INSL:  res = (a & fmask) << sh;
            K_INSH:  res = off_zero ? '0 : ((a & fmask) >> cpl);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bytemix_zap.sv
module bytemix_zap #(
    parameter int DW = 64
) (
    input  logic [DW-1:0]   a,
    input  logic [DW/8-1:0] sel,
    input  logic            keep_sel,
    output logic [DW-1:0]   res
);
    localparam int NB = DW / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic keep;
        assign keep = keep_sel ? sel[i] : ~sel[i];
        assign res[i*8 +: 8] = keep ? a[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/bytemix_unit.sv
module bytemix_unit
    import bytemix_pkg::*;
#(
    parameter int DW = 64,
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [FW-1:0] func,
    output logic [DW-1:0] result,
    output logic          bad_func
);
    localparam int NB = DW / 8;
    localparam int OW = $clog2(NB);
    localparam int SW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] res;
        logic          bad;
    } out_t;

    op_kind_e      kind;
    logic [1:0]    size;
    logic [DW-1:0] field_res;
    logic [DW-1:0] zap_res;
    logic          unused_b;
    out_t          out_d, out_q;

    assign unused_b = ^op_b[DW-1:NB];

    bytemix_decode u_dec (
        .func (func),
        .kind (kind),
        .size (size)
    );

    bytemix_field #(.DW(DW)) u_field (
        .a    (op_a),
        .off  (op_b[OW-1:0]),
        .size (size),
        .kind (kind),
        .res  (field_res)
    );

    bytemix_zap #(.DW(DW)) u_zap (
        .a        (op_a),
        .sel      (op_b[NB-1:0]),
        .keep_sel (kind == K_ZAPNOT),
        .res      (zap_res)
    );

    always_comb begin
        out_d     = '0;
        out_d.bad = (kind == K_BAD);
        case (kind)
            K_ZAP, K_ZAPNOT: out_d.res = zap_res;
            K_SLL:           out_d.res = op_a << op_b[SW-1:0];
            K_SRL:           out_d.res = op_a >> op_b[SW-1:0];
            K_SRA:           out_d.res = DW'($signed(op_a) >>> op_b[SW-1:0]);
            K_BAD:           out_d.res = '0;
            default:         out_d.res = field_res;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result   = out_q.res;
    assign bad_func = out_q.bad;
endmodule

// File: rtl/bytemix_chk.sv
module bytemix_chk #(
    parameter int DW = 64,
    parameter int FW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [FW-1:0] func,
    input logic [DW-1:0] result,
    input logic          bad_func
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_mskl_subset_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(func) == 7'h12) |-> ((result & ~$past(op_a)) == '0));

    p_mskh_pass_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (($past(func) == 7'h72) && ($past(op_b[2:0]) == 3'd0)) |-> (result == $past(op_a)));

    p_extl_byte_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(func) == 7'h06) |-> (result[DW-1:8] == '0));

    p_insh_zero_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (($past(func) == 7'h67) && ($past(op_b[2:0]) == 3'd0)) |-> (result == '0));

    p_zap_subset_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (($past(func) == 7'h30) || ($past(func) == 7'h31)) |-> ((result & ~$past(op_a)) == '0));

    p_bad_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_func |-> (result == '0));

    p_legal_flag_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(func) == 7'h3C) |-> !bad_func);
endmodule

bind bytemix_unit bytemix_chk #(.DW(DW), .FW(FW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .func     (func),
    .result   (result),
    .bad_func (bad_func)
);

// File: tb/tb_bytemix_unit.sv
`timescale 1ns/1ps
module tb_bytemix_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [6:0]  func = '0;
    logic [63:0] result;
    logic        bad_func;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bytemix_unit dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .func(func), .result(result), .bad_func(bad_func)
    );

    localparam logic [6:0] FIELD_CODES [21] = '{
        7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
        7'h06, 7'h16, 7'h26, 7'h36, 7'h5A, 7'h6A, 7'h7A,
        7'h0B, 7'h1B, 7'h2B, 7'h3B, 7'h57, 7'h67, 7'h77};

    localparam logic [63:0] PATS [3] = '{
        64'h8877_6655_4433_2211, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0E1_D2C3_B4A5_9687};

    function automatic bit is_legal(input logic [6:0] f);
        foreach (FIELD_CODES[k]) if (FIELD_CODES[k] == f) return 1'b1;
        return (f == 7'h30 || f == 7'h31 || f == 7'h39 || f == 7'h34 || f == 7'h3C);
    endfunction

    function automatic string req_of(input logic [6:0] f);
        case (f)
            7'h02, 7'h12, 7'h22, 7'h32: return "R3";
            7'h52, 7'h62, 7'h72:        return "R4";
            7'h06, 7'h16, 7'h26, 7'h36: return "R5";
            7'h5A, 7'h6A, 7'h7A:        return "R6";
            7'h0B, 7'h1B, 7'h2B, 7'h3B: return "R7";
            7'h57, 7'h67, 7'h77:        return "R8";
            7'h30, 7'h31:               return "R9";
            7'h39, 7'h34, 7'h3C:        return "R10";
            default:                    return "R11";
        endcase
    endfunction

    // Byte- and bit-level reference built from the requirement text.
    function automatic logic [63:0] model(input logic [6:0] f, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r = '0;
        int off = int'(b[2:0]);
        int nb  = 1 << f[5:4];
        int n   = int'(b[5:0]);
        int s   = (8 - off) % 8;
        string q = req_of(f);
        for (int j = 0; j < 8; j++) begin
            case (q)
                "R3": r[8*j +: 8] = (j >= off && j < off + nb) ? 8'h00 : a[8*j +: 8];
                "R4": r[8*j +: 8] = (off != 0 && j < off + nb - 8) ? 8'h00 : a[8*j +: 8];
                "R5": if (j < nb && j + off < 8) r[8*j +: 8] = a[8*(j+off) +: 8];
                "R6": if (j < nb && j >= s) r[8*j +: 8] = a[8*(j-s) +: 8];
                "R7": if (j >= off && j - off < nb) r[8*j +: 8] = a[8*(j-off) +: 8];
                "R8": if (off != 0 && j + 8 - off < nb) r[8*j +: 8] = a[8*(j+8-off) +: 8];
                "R9": r[8*j +: 8] = (b[j] ^ f[0]) ? 8'h00 : a[8*j +: 8];
                default: ;
            endcase
        end
        if (q == "R10") begin
            for (int i = 0; i < 64; i++) begin
                if (f == 7'h39)      r[i] = (i >= n) ? a[i-n] : 1'b0;
                else if (f == 7'h34) r[i] = (i + n < 64) ? a[i+n] : 1'b0;
                else                 r[i] = (i + n < 64) ? a[i+n] : a[63];
            end
        end
        return r;
    endfunction

    task automatic check(input string rq, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (func %h a %h b %h)", rq, got, exp, func, op_a, op_b);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (one register stage).
    task automatic apply(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        func = f; op_a = a; op_b = b;
        @(negedge clk);
        check(req_of(f), result, is_legal(f) ? model(f, a, b) : 64'h0);
        check(is_legal(f) ? "R11" : req_of(f), {63'h0, bad_func}, {63'h0, !is_legal(f)});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r_first;
        func = 7'h32; op_a = PATS[0]; op_b = 64'h5;
        repeat (3) @(negedge clk);
        check("R1", result, 64'h0);
        check("R1", {63'h0, bad_func}, 64'h0);
        rst_n = 1'b1;
        #1;
        check("R1", result, 64'h0);
        @(negedge clk);
        check("R3", result, model(7'h32, PATS[0], 64'h5));

        // R1: new inputs not visible before the next rising edge
        func = 7'h7F; op_a = '1;
        #1;
        check("R1", {63'h0, bad_func}, 64'h0);
        @(negedge clk);
        check("R11", {63'h0, bad_func}, 64'h1);

        // R3..R8 sweep: every field code, every offset, random upper B bits (R2)
        foreach (FIELD_CODES[c])
            for (int off = 0; off < 8; off++)
                for (int p = 0; p < 3; p++)
                    apply(FIELD_CODES[c], PATS[p], {$urandom, $urandom(), 3'b000} | 64'(off));

        // R2: upper B bits have no effect
        apply(7'h26, PATS[2], 64'h3);
        r_first = result;
        apply(7'h26, PATS[2], 64'hABCD_EF01_2345_6783);
        check("R2", result, r_first);

        // R9: every byte bitmap, both polarities
        for (int m = 0; m < 256; m++) begin
            apply(7'h30, PATS[2], {$urandom, $urandom()} & ~64'hFF | 64'(m));
            apply(7'h31, PATS[2], 64'(m));
        end

        // R10: every count, positive and negative operand
        for (int n = 0; n < 64; n++) begin
            apply(7'h39, PATS[2], 64'(n) | 64'hFFC0);
            apply(7'h34, PATS[2], 64'(n));
            apply(7'h3C, PATS[2], 64'(n));
            apply(7'h3C, 64'h7EDC_BA98_7654_3210, 64'(n));
        end

        // R11: sweep of all function codes
        for (int f = 0; f < 128; f++) apply(7'(f), PATS[0], 64'h13);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule